// File: doc/BRIEF.md
# Paper Tape Block Loader

The block accepts 8-bit frames from a tape reader and assembles them into 16-bit words, which it writes into a word-addressed memory through an address/data/strobe port. A load runs as follows. Zero frames are skipped. The first nonzero frame opens a block. Each word in the block is a record of three frames: a control frame, then the high byte, then the low byte. A zero control frame where the next record would start closes the block. The control frame carries no data. Only its zero or nonzero value matters.

A start pulse begins a load. It samples an optional origin (octal 0200 when none is offered) and a continue flag. With the flag clear, the loader stops after the first block. With the flag set, it goes back to skipping zeros and keeps loading blocks until end of tape. End of tape is legal wherever a control frame or a leading zero could appear. Inside a word record it is a format error. A word aimed past the configured memory size aborts the load. The done flag, the error flag and the error code stay asserted until the next start.

Top module: `tape_loader`

## Requirements
- R1: Zero frames before a block are consumed without a write. The first nonzero frame is taken as the control frame of the block's first word.
- R2: Each stored word equals (high frame << 8) | low frame. Any nonzero control value (for example 0x01, 0x80 or 0xFF) gives the same result.
- R3: The first word goes to `org_i` when `org_valid_i` was high at start, otherwise to address 128 (octal 0200). Each later word goes to the previous address plus one.
- R4: With `cont_i` low at start, a zero control frame ends the load with `done_o`=1 and `err_code_o`=0. After that `frame_ready_o` stays low and offered frames cause no write.
- R5: With `cont_i` high at start, a zero control frame returns the loader to zero skipping. Later blocks then load at the following addresses.
- R6: End of tape (`eot_i`) where a leading zero or a control frame is expected ends the load with `done_o`=1 and `err_code_o`=0.
- R7: End of tape in place of a high or low frame ends the load with `done_o`=1, `err_o`=1 and `err_code_o`=1 (format error). No further write occurs.
- R8: When a high frame is accepted for an address at or above `MEM_WORDS`, the word is not written. The load ends with `done_o`=1, `err_o`=1 and `err_code_o`=2 (nonexistent memory).
- R9: `mem_we_o` is a one-cycle pulse in the cycle after the low frame is accepted, and `frame_ready_o` is low during that cycle.
- R10: Out of reset and after every start, `done_o` and `err_o` are low. Once set, `done_o` and `err_code_o` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; samples origin and mode, clears status |
| cont_i | input | 1 | Continue across blocks until end of tape |
| org_valid_i | input | 1 | Use `org_i` as origin instead of the default |
| org_i | input | ADDR_W | Load origin |
| frame_valid_i | input | 1 | Frame offered |
| frame_i | input | FRAME_W | Frame value |
| frame_ready_o | output | 1 | Loader accepts a frame this cycle |
| eot_i | input | 1 | End of tape strobe; wins over a frame in the same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_data_o | output | 2*FRAME_W | Memory write data |
| done_o | output | 1 | Load finished, successfully or not |
| err_o | output | 1 | Load finished with an error |
| err_code_o | output | 2 | 0 none, 1 format, 2 nonexistent memory |

## Verification
The tests cover several stimulus patterns:
- Single-block loads with leading zeros and varied nonzero control values. These separate the control frame from data and show where the block ends.
- Continue-mode loads of two blocks with zero gaps at three origins. These confirm that address counting carries across blocks.
- A 64-word block with computed words. This tests byte placement over many bit patterns.
- End of tape at each of the four frame positions. These separate a clean finish from a format error.
- A load that starts two words below the memory limit. This pins the exact word at which the range error occurs.

// File: rtl/tape_loader_pkg.sv
package tape_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_HI, ST_LO, ST_WR, ST_CTRL, ST_END
  } ld_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_FMT  = 2'd1,
    ERR_NXM  = 2'd2
  } ld_err_e;
endpackage

// File: rtl/tape_loader_fsm.sv
module tape_loader_fsm
  import tape_loader_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cont_i,
  input  logic       frame_valid_i,
  input  logic       frame_zero_i,
  input  logic       eot_i,
  input  logic       oor_i,
  output logic       frame_ready_o,
  output logic       hi_ld_o,
  output logic       lo_ld_o,
  output logic       we_o,
  output logic       done_o,
  output logic [1:0] err_code_o
);
  ld_state_e state_q, state_d;
  ld_err_e   code_q, code_d;
  logic      cont_q, done_q, done_d;
  logic      listening, take, eot_hit;

  assign listening = (state_q == ST_SKIP) || (state_q == ST_HI) ||
                     (state_q == ST_LO)   || (state_q == ST_CTRL);
  assign eot_hit   = eot_i & listening;
  assign take      = frame_valid_i & listening & ~eot_i;

  assign frame_ready_o = listening;
  assign hi_ld_o       = (state_q == ST_HI) & take & ~oor_i;
  assign lo_ld_o       = (state_q == ST_LO) & take;
  assign we_o          = (state_q == ST_WR);
  assign done_o        = done_q;
  assign err_code_o    = code_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    done_d  = done_q;
    unique case (state_q)
      ST_SKIP: begin
        if (eot_hit) begin
          state_d = ST_END; done_d = 1'b1;
        end else if (take && !frame_zero_i) state_d = ST_HI;
      end
      ST_HI: begin
        if (eot_hit) begin
          state_d = ST_END; done_d = 1'b1; code_d = ERR_FMT;
        end else if (take) begin
          if (oor_i) begin
            state_d = ST_END; done_d = 1'b1; code_d = ERR_NXM;
          end else state_d = ST_LO;
        end
      end
      ST_LO: begin
        if (eot_hit) begin
          state_d = ST_END; done_d = 1'b1; code_d = ERR_FMT;
        end else if (take) state_d = ST_WR;
      end
      ST_WR: state_d = ST_CTRL;
      ST_CTRL: begin
        if (eot_hit) begin
          state_d = ST_END; done_d = 1'b1;
        end else if (take) begin
          if (!frame_zero_i) state_d = ST_HI;
          else if (cont_q) state_d = ST_SKIP;
          else begin
            state_d = ST_END; done_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (start_i) begin
      state_d = ST_SKIP;
      code_d  = ERR_NONE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      done_q  <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      done_q  <= done_d;
      if (start_i) cont_q <= cont_i;
    end
  end
endmodule

// File: rtl/tape_loader_addr.sv
module tape_loader_addr #(
  parameter int ADDR_W     = 8,
  parameter int MEM_WORDS  = 200,
  parameter int DEF_ORIGIN = 'o200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              org_valid_i,
  input  logic [ADDR_W-1:0] org_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              oor_o
);
  // one spare bit so a wrap past the top still reads as out of range
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MEM_WORDS);
  localparam logic [ADDR_W-1:0] DEF_ORG = ADDR_W'(DEF_ORIGIN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= {1'b0, org_valid_i ? org_i : DEF_ORG};
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign addr_o = cnt_q[ADDR_W-1:0];
  assign oor_o  = (cnt_q >= LIMIT);
endmodule

// File: rtl/tape_loader_word.sv
module tape_loader_word #(
  parameter int FRAME_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hi_ld_i,
  input  logic                 lo_ld_i,
  input  logic [FRAME_W-1:0]   frame_i,
  output logic [2*FRAME_W-1:0] word_o
);
  logic [FRAME_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_ld_i) hi_q <= frame_i;
      if (lo_ld_i) lo_q <= frame_i;
    end
  end

  assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
  parameter int FRAME_W    = 8,
  parameter int ADDR_W     = 8,
  parameter int MEM_WORDS  = 200,
  parameter int DEF_ORIGIN = 'o200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 cont_i,
  input  logic                 org_valid_i,
  input  logic [ADDR_W-1:0]    org_i,
  input  logic                 frame_valid_i,
  input  logic [FRAME_W-1:0]   frame_i,
  output logic                 frame_ready_o,
  input  logic                 eot_i,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [2*FRAME_W-1:0] mem_data_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [1:0]           err_code_o
);
  logic hi_ld, lo_ld, oor;

  tape_loader_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .cont_i        (cont_i),
    .frame_valid_i (frame_valid_i),
    .frame_zero_i  (frame_i == '0),
    .eot_i         (eot_i),
    .oor_i         (oor),
    .frame_ready_o (frame_ready_o),
    .hi_ld_o       (hi_ld),
    .lo_ld_o       (lo_ld),
    .we_o          (mem_we_o),
    .done_o        (done_o),
    .err_code_o    (err_code_o)
  );

  tape_loader_addr #(
    .ADDR_W     (ADDR_W),
    .MEM_WORDS  (MEM_WORDS),
    .DEF_ORIGIN (DEF_ORIGIN)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .org_valid_i (org_valid_i),
    .org_i       (org_i),
    .inc_i       (mem_we_o),
    .addr_o      (mem_addr_o),
    .oor_o       (oor)
  );

  tape_loader_word #(.FRAME_W(FRAME_W)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_ld_i (hi_ld),
    .lo_ld_i (lo_ld),
    .frame_i (frame_i),
    .word_o  (mem_data_o)
  );

  assign err_o = (err_code_o != 2'd0);
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
  parameter int ADDR_W    = 8,
  parameter int MEM_WORDS = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              frame_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        err_code_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

  AST_WRITE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ({1'b0, mem_addr_o} < LIMIT)); // R8
  AST_WE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !frame_ready_o); // R9
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R10
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(err_code_o)); // R10
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !err_o)); // R10
  AST_ERR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!frame_ready_o && !mem_we_o)); // R4
endmodule

bind tape_loader tape_loader_chk #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .frame_ready_o (frame_ready_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .err_code_o    (err_code_o)
);

// File: tb/tape_loader_tb.sv
`timescale 1ns/1ps
module tape_loader_tb;
  localparam int ADDR_W = 8;
  localparam int MEM_WORDS = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cont = 0, org_valid = 0, fvalid = 0, eot = 0;
  logic [ADDR_W-1:0] org = '0;
  logic [7:0] frame = '0;
  logic fready, we, done, err;
  logic [ADDR_W-1:0] addr;
  logic [15:0] data;
  logic [1:0] code;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [15:0] bmem [256];

  always #4 clk = ~clk;

  tape_loader #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .org_valid_i(org_valid), .org_i(org), .frame_valid_i(fvalid),
    .frame_i(frame), .frame_ready_o(fready), .eot_i(eot),
    .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(data),
    .done_o(done), .err_o(err), .err_code_o(code)
  );

  always @(posedge clk) if (we) begin
    bmem[addr] <= data;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_load(input bit c, input bit ov, input logic [ADDR_W-1:0] o);
    @(negedge clk);
    start = 1; cont = c; org_valid = ov; org = o;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!fready) @(negedge clk);
    fvalid = 1; frame = b;
    @(negedge clk);
    fvalid = 0;
  endtask

  task automatic send_eot();
    @(negedge clk);
    while (!fready) @(negedge clk);
    eot = 1;
    @(negedge clk);
    eot = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] sweep_word(input int k, input int seed);
    return 16'((k * 16'h0403) ^ (seed * 16'h0101) ^ 16'h5AA5);
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] ctl [3];
    logic [15:0] w [3];
    ctl[0] = 8'h01; ctl[1] = 8'h80; ctl[2] = 8'hFF;
    w[0] = 16'h1234; w[1] = 16'hABCD; w[2] = 16'h00FF;

    repeat (3) @(negedge clk);
    chk(!done && !err && !fready && !we, "R10 reset state", {done, err, fready, we}, 0);
    rst_n = 1;
    @(negedge clk);

    // single block, default origin
    begin_load(0, 0, '0);
    chk(!done && !err, "R10 start clears", {done, err}, 0);
    base = wr_cnt;
    send(8'h00); send(8'h00); send(8'h00);
    chk(wr_cnt == base, "R1 zeros not written", wr_cnt - base, 0);
    for (int i = 0; i < 3; i++) begin
      send(ctl[i]); send(w[i][15:8]); send(w[i][7:0]);
      if (i == 0) chk(we && !fready, "R9 write after low frame", {we, fready}, 2);
    end
    send(8'h00);
    wait_done();
    chk(done && code == 0, "R4 single block done", {done, code}, 4);
    for (int i = 0; i < 3; i++)
      chk(bmem[128 + i] == w[i], "R2 R3 word at default origin", bmem[128 + i], w[i]);
    chk(wr_cnt - base == 3, "R1 write count", wr_cnt - base, 3);
    @(negedge clk);
    fvalid = 1; frame = 8'h05;
    repeat (6) @(negedge clk);
    chk(!fready && wr_cnt - base == 3 && done && code == 0, "R4 frames after end ignored",
        wr_cnt - base, 3);
    fvalid = 0;
    repeat (4) @(negedge clk);
    chk(done && code == 0, "R10 status held", {done, code}, 4);

    // continue mode, two blocks, several origins
    for (int t = 0; t < 3; t++) begin
      int o;
      o = (t == 0) ? 0 : (t == 1) ? 37 : 150;
      begin_load(1, 1, ADDR_W'(o));
      base = wr_cnt;
      send(8'h00);
      for (int k = 0; k < 8; k++) begin
        logic [15:0] v;
        v = sweep_word(k, o);
        if (k == 4) begin send(8'h00); send(8'h00); end
        send(8'(k + 1)); send(v[15:8]); send(v[7:0]);
      end
      send_eot();
      wait_done();
      chk(done && code == 0, "R5 R6 continue end of tape ok", {done, code}, 4);
      chk(wr_cnt - base == 8, "R5 both blocks written", wr_cnt - base, 8);
      for (int k = 0; k < 8; k++)
        chk(bmem[o + k] == sweep_word(k, o), "R3 R5 word across blocks", bmem[o + k],
            sweep_word(k, o));
    end

    // long block sweep of data patterns
    begin_load(0, 1, 8'd0);
    base = wr_cnt;
    for (int k = 0; k < 64; k++) begin
      logic [15:0] v;
      v = sweep_word(k, 7) ^ 16'(k << 9);
      send(8'h40); send(v[15:8]); send(v[7:0]);
    end
    send(8'h00);
    wait_done();
    chk(done && code == 0 && wr_cnt - base == 64, "R4 long block", wr_cnt - base, 64);
    for (int k = 0; k < 64; k++)
      chk(bmem[k] == (sweep_word(k, 7) ^ 16'(k << 9)), "R2 sweep word", bmem[k],
          sweep_word(k, 7) ^ 16'(k << 9));

    // end of tape at each position
    begin_load(0, 0, '0);
    send_eot(); wait_done();
    chk(done && code == 0 && !err, "R6 eot in zero skip", {done, code}, 4);
    begin_load(0, 0, '0);
    base = wr_cnt;
    send(8'h05); send_eot(); wait_done();
    chk(done && err && code == 1, "R7 eot at high frame", code, 1);
    begin_load(0, 0, '0);
    send(8'h05); send(8'h12); send_eot(); wait_done();
    chk(done && err && code == 1, "R7 eot at low frame", code, 1);
    chk(wr_cnt == base, "R7 no write on format error", wr_cnt - base, 0);
    begin_load(0, 0, '0);
    chk(!done && !err && code == 0, "R10 start clears error", code, 0);
    send(8'h05); send(8'h12); send(8'h34); send_eot(); wait_done();
    chk(done && code == 0 && bmem[128] == 16'h1234, "R6 eot at control frame", bmem[128], 16'h1234);

    // range limit
    begin_load(0, 1, 8'd198);
    base = wr_cnt;
    send(8'h01); send(8'hC1); send(8'h01);
    send(8'h02); send(8'hC2); send(8'h02);
    send(8'h03); send(8'hC3);
    wait_done();
    chk(done && err && code == 2, "R8 nonexistent memory", code, 2);
    chk(wr_cnt - base == 2, "R8 write count at limit", wr_cnt - base, 2);
    chk(bmem[198] == 16'hC101 && bmem[199] == 16'hC202, "R8 last legal words", bmem[199], 16'hC202);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule